// File: doc/BRIEF.md
# Serial-Access Real-Time Clock Register File

This block is a four-wire serial peripheral that holds the register space of a calendar clock. It contains BCD time and calendar registers, two alarm register sets, a control register, a status location, a charge-setting byte and a user scratch RAM. A host reads and writes these registers over a link with an active-high select, using clock-idle-high framing with sampling on the rising edge. Every transaction opens with an address byte. Its top bit chooses write (1) or read (0), and its low seven bits give the starting register. Each later byte in the same select window moves to the next address. A write-lock bit in the control register freezes every other register.

A one-cycle `tick` pulse, generated elsewhere once per second, advances the clock. Seconds, minutes and hours roll over in BCD, with 12-hour and 24-hour hour formats. The weekday cycles 1 to 7. The date follows month lengths, and February has 29 days when the two-digit year is divisible by 4. The month and the two-digit year also roll over. The serial pins are sampled in the `clk` domain. Each SCK level must last at least three `clk` cycles, and select must rise at least two cycles before the first SCK edge.

Transactions are sequenced by a four-state machine. The states are XS_IDLE (deselected), XS_CMD (receiving the address byte), XS_WR (write data bytes) and XS_RD (read data bytes). The transitions are:
- XS_IDLE to XS_CMD when select rises.
- XS_CMD to XS_WR on an address byte with bit 7 set.
- XS_CMD to XS_RD on an address byte with bit 7 clear.
- Any state to XS_IDLE when select is low.

Top module: `rtc_spi_regfile`

## Requirements
- R1: `cs` is active high. SCK idles high, MOSI is sampled on SCK rising edges, MSB first. Read data is driven on MISO from each SCK falling edge. MISO is 0 whenever `cs` is low.
- R2: In the first byte of a transaction, bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6:0 are the register address.
- R3: Each data byte after the first uses the next address, in both reads and writes. The address wraps from 0x7F to 0x00.
- R4: The following locations are readable and writable: alarm bytes 0x07–0x0E, the charge setting at 0x11, and user RAM at 0x20–0x3F. Location 0x10 (status), 0x12–0x1F and 0x40–0x7F read as 0x00 and ignore writes.
- R5: After reset the registers read as follows: seconds 0x00, minutes 0x00, hours 0x00, weekday (0x03) 0x01, date (0x04) 0x01, month (0x05) 0x01, year (0x06) 0x00, control (0x0F) 0x40, everything else 0x00.
- R6: If control bit 6 (write lock) is set when `cs` rises, all writes in that transaction to addresses other than 0x0F are ignored. This holds even if the same transaction clears the lock.
- R7: A control write in a locked transaction changes only bit 6. In an unlocked transaction, bits 6, 2, 1 and 0 take the written value. Bits 7 and 5:3 always read 0.
- R8: On a tick, seconds (0x00) and minutes (0x01) count in BCD. 0x59 wraps to 0x00 and carries.
- R9: Hours (0x02) with bit 6 = 0 count 0x00–0x23 and carry on wrap. With bit 6 = 1 the hour is BCD 1–12 in bits 4:0, with PM in bit 5. 11 goes to 12 and toggles PM, 12 goes to 1, and the day carries when 11 PM goes to 12 AM.
- R10: On a day carry, the weekday (0x03) goes 7 to 1, and otherwise increments. The date (0x04) goes back to 0x01 after the month's last day: 30 for months 4, 6, 9 and 11, 29 or 28 for month 2 (29 when the year is divisible by 4), and 31 otherwise.
- R11: On a month carry, the month (0x05) goes 0x12 to 0x01. On a year carry, the year (0x06) goes 0x99 to 0x00.
- R12: A tick arriving while a write transaction is open is discarded and the time registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Active-high chip select |
| sck | input | 1 | Serial clock, idle high |
| mosi | input | 1 | Serial data in |
| tick | input | 1 | One-cycle pulse, once per second |
| miso | output | 1 | Serial data out |

## Verification
Several rules are checked by assertions on every cycle:
- The machine returns to idle when deselected.
- Writes occur only inside an open write window.
- The address pointer steps once per data byte.
- A locked transaction leaves the seconds register and the low control bits unchanged.
- Seconds and weekday wrap on a tick.
- Seconds do not move while a write is open.

Only the bench scenarios can show the end-to-end behaviour:
- Bit ordering on the wire.
- Address wrap and the map of holes.
- A lock being cleared but still honoured within the same transaction.
- Month lengths, the leap year and the 12-hour AM/PM crossings.

The bench checks these against a behavioural register model after each transaction.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int ALARM_N = 8;

    typedef logic [ADDR_W-1:0] raddr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam raddr_t A_SEC  = 7'h00;
    localparam raddr_t A_MIN  = 7'h01;
    localparam raddr_t A_HOUR = 7'h02;
    localparam raddr_t A_DOW  = 7'h03;
    localparam raddr_t A_DATE = 7'h04;
    localparam raddr_t A_MON  = 7'h05;
    localparam raddr_t A_YEAR = 7'h06;
    localparam raddr_t A_ALM0 = 7'h07;
    localparam raddr_t A_CTRL = 7'h0F;
    localparam raddr_t A_CHRG = 7'h11;

    localparam byte_t CTRL_LOCK = 8'h40;
    localparam byte_t CTRL_MASK = 8'h47;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_CMD,
        XS_WR,
        XS_RD
    } xs_t;

    function automatic byte_t bcd_inc(input byte_t v);
        return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    function automatic logic leap_year(input byte_t y);
        // two-digit BCD year divisible by four
        logic [6:0] bin;
        bin = {3'b000, y[7:4]} * 7'd10 + {3'b000, y[3:0]};
        return bin[1:0] == 2'b00;
    endfunction

    function automatic byte_t month_len(input byte_t mon, input byte_t yr);
        byte_t r;
        case (mon)
            8'h02:   r = leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default: r = 8'h31;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rtcs_spi_phy.sv
module rtcs_spi_phy
    import rtcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs,
    input  logic  sck,
    input  logic  mosi,
    input  byte_t tx_byte,
    output logic  miso,
    output logic  sel,
    output logic  start,
    output logic  byte_vld,
    output byte_t rx_byte
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic                 cs_q;
    logic                 sck_q;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [BYTE_W-2:0]    rx_sh;
    byte_t                tx_sh;
    logic                 active;
    logic                 sck_rise;
    logic                 sck_fall;

    assign active   = cs & cs_q;
    assign sck_rise = active & sck & ~sck_q;
    assign sck_fall = active & ~sck & sck_q;
    assign sel      = cs_q;
    assign miso     = active ? tx_sh[BYTE_W-1] : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b0;
            sck_q    <= 1'b1;
            start    <= 1'b0;
            byte_vld <= 1'b0;
            bitcnt   <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            tx_sh    <= '0;
        end else begin
            cs_q     <= cs;
            sck_q    <= sck;
            start    <= cs & ~cs_q;
            byte_vld <= 1'b0;
            if (cs & ~cs_q) begin
                bitcnt <= '0;
                tx_sh  <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sh  <= {rx_sh[BYTE_W-3:0], mosi};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        byte_vld <= 1'b1;
                        rx_byte  <= {rx_sh, mosi};
                    end
                end
                if (sck_fall) begin
                    tx_sh <= (bitcnt == '0) ? tx_byte : {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    AST_BYTE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(cs)); // R1
endmodule

// File: rtl/rtcs_xact_ctl.sv
module rtcs_xact_ctl
    import rtcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel,
    input  logic   start,
    input  logic   byte_vld,
    input  byte_t  rx_byte,
    output raddr_t ptr,
    output logic   wr_stb,
    output logic   wr_active
);
    xs_t state;
    xs_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!sel) begin
            nxt = XS_IDLE;
        end else begin
            unique case (state)
                XS_IDLE: if (start) nxt = XS_CMD;
                XS_CMD:  if (byte_vld) nxt = rx_byte[BYTE_W-1] ? XS_WR : XS_RD;
                XS_WR:   nxt = XS_WR;
                XS_RD:   nxt = XS_RD;
            endcase
        end
    end

    always_comb begin
        wr_active = (state == XS_WR);
        wr_stb    = (state == XS_WR) && byte_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (byte_vld) begin
            if (state == XS_CMD)
                ptr <= rx_byte[ADDR_W-1:0];
            else if (state == XS_WR || state == XS_RD)
                ptr <= ptr + 1'b1;
        end
    end

    AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> state == XS_IDLE); // R1
    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sel); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && (state == XS_WR || state == XS_RD)) |=> ptr == $past(ptr) + 1'b1); // R3
endmodule

// File: rtl/rtcs_regbank.sv
module rtcs_regbank
    import rtcs_pkg::*;
#(
    parameter int RAM_BASE  = 32,
    parameter int RAM_DEPTH = 32
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   xact_start,
    input  logic   wr_stb,
    input  logic   wr_active,
    input  raddr_t wr_addr,
    input  byte_t  wr_data,
    input  logic   tick,
    input  raddr_t rd_addr,
    output byte_t  rd_data
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam int RAM_END = RAM_BASE + RAM_DEPTH;

    byte_t sec_r, min_r, hr_r, dow_r, date_r, mon_r, yr_r;
    byte_t ctrl_r, chrg_r;
    byte_t alarm_r [ALARM_N];
    byte_t ram_r   [RAM_DEPTH];
    logic  wp_snap;
    logic  wr_ok;

    byte_t sec_n, min_n, hr_n, dow_n, date_n, mon_n, yr_n;
    logic  c_sec, c_min, c_hr, c_date, c_mon;
    byte_t last_day;

    assign wr_ok = wr_stb && !wp_snap;

    // one-second advance of the calendar
    always_comb begin
        last_day = month_len(mon_r, yr_r);
        c_sec = (sec_r == 8'h59);
        sec_n = c_sec ? 8'h00 : bcd_inc(sec_r);
        c_min = c_sec && (min_r == 8'h59);
        min_n = !c_sec ? min_r : ((min_r == 8'h59) ? 8'h00 : bcd_inc(min_r));
        hr_n  = hr_r;
        c_hr  = 1'b0;
        if (c_min) begin
            if (hr_r[6]) begin
                if (hr_r[4:0] == 5'h11) begin
                    hr_n = {2'b01, ~hr_r[5], 5'h12};
                    c_hr = hr_r[5];
                end else if (hr_r[4:0] == 5'h12) begin
                    hr_n = {2'b01, hr_r[5], 5'h01};
                end else begin
                    hr_n = {2'b01, hr_r[5], 5'b0} | (bcd_inc({3'b000, hr_r[4:0]}) & 8'h1F);
                end
            end else if (hr_r[5:0] == 6'h23) begin
                hr_n = 8'h00;
                c_hr = 1'b1;
            end else begin
                hr_n = bcd_inc({2'b00, hr_r[5:0]});
            end
        end
        dow_n  = !c_hr ? dow_r : ((dow_r >= 8'd7) ? 8'd1 : dow_r + 8'd1);
        c_date = c_hr && (date_r == last_day);
        date_n = !c_hr ? date_r : (c_date ? 8'h01 : bcd_inc(date_r));
        c_mon  = c_date && (mon_r == 8'h12);
        mon_n  = !c_date ? mon_r : (c_mon ? 8'h01 : bcd_inc(mon_r));
        yr_n   = !c_mon ? yr_r : ((yr_r == 8'h99) ? 8'h00 : bcd_inc(yr_r));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_r   <= 8'h00;
            min_r   <= 8'h00;
            hr_r    <= 8'h00;
            dow_r   <= 8'h01;
            date_r  <= 8'h01;
            mon_r   <= 8'h01;
            yr_r    <= 8'h00;
            ctrl_r  <= CTRL_LOCK;
            chrg_r  <= 8'h00;
            wp_snap <= 1'b1;
        end else begin
            if (xact_start) wp_snap <= ctrl_r[6];
            if (wr_stb && wr_addr == A_CTRL) begin
                ctrl_r <= wp_snap ? ((ctrl_r & ~CTRL_LOCK) | (wr_data & CTRL_LOCK))
                                  : (wr_data & CTRL_MASK);
            end
            if (wr_ok) begin
                case (wr_addr)
                    A_SEC:   sec_r  <= wr_data;
                    A_MIN:   min_r  <= wr_data;
                    A_HOUR:  hr_r   <= wr_data;
                    A_DOW:   dow_r  <= wr_data;
                    A_DATE:  date_r <= wr_data;
                    A_MON:   mon_r  <= wr_data;
                    A_YEAR:  yr_r   <= wr_data;
                    A_CHRG:  chrg_r <= wr_data;
                    default: ;
                endcase
            end else if (tick && !wr_active) begin
                sec_r  <= sec_n;
                min_r  <= min_n;
                hr_r   <= hr_n;
                dow_r  <= dow_n;
                date_r <= date_n;
                mon_r  <= mon_n;
                yr_r   <= yr_n;
            end
        end
    end

    for (genvar g = 0; g < ALARM_N; g++) begin : g_alarm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alarm_r[g] <= '0;
            else if (wr_ok && wr_addr == raddr_t'(int'(A_ALM0) + g))
                alarm_r[g] <= wr_data;
        end
    end

    for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ram_r[g] <= '0;
            else if (wr_ok && wr_addr == raddr_t'(RAM_BASE + g))
                ram_r[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_SEC:   rd_data = sec_r;
            A_MIN:   rd_data = min_r;
            A_HOUR:  rd_data = hr_r;
            A_DOW:   rd_data = dow_r;
            A_DATE:  rd_data = date_r;
            A_MON:   rd_data = mon_r;
            A_YEAR:  rd_data = yr_r;
            A_CTRL:  rd_data = ctrl_r;
            A_CHRG:  rd_data = chrg_r;
            default: begin
                if (int'(rd_addr) >= int'(A_ALM0) && int'(rd_addr) < int'(A_ALM0) + ALARM_N)
                    rd_data = alarm_r[3'(rd_addr - A_ALM0)];
                else if (int'(rd_addr) >= RAM_BASE && int'(rd_addr) < RAM_END)
                    rd_data = ram_r[RAM_AW'(rd_addr - raddr_t'(RAM_BASE))];
            end
        endcase
    end

    AST_LOCK_HOLDS_SECONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_snap && wr_stb && wr_addr == A_SEC) |=> $stable(sec_r)); // R6
    AST_LOCK_HOLDS_CTRL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_snap && wr_stb) |=> ctrl_r[2:0] == $past(ctrl_r[2:0])); // R7
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_active && !wr_stb && sec_r == 8'h59) |=> sec_r == 8'h00); // R8
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_active && !wr_stb && c_hr && dow_r == 8'd7) |=> dow_r == 8'd1); // R10
    AST_TICK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && !wr_stb) |=> $stable(sec_r)); // R12
endmodule

// File: rtl/rtc_spi_regfile.sv
module rtc_spi_regfile
    import rtcs_pkg::*;
#(
    parameter int RAM_BASE  = 32,
    parameter int RAM_DEPTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic mosi,
    input  logic tick,
    output logic miso
);
    byte_t  tx_byte;
    byte_t  rx_byte;
    logic   sel;
    logic   start;
    logic   byte_vld;
    raddr_t ptr;
    logic   wr_stb;
    logic   wr_active;

    rtcs_spi_phy u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .sck      (sck),
        .mosi     (mosi),
        .tx_byte  (tx_byte),
        .miso     (miso),
        .sel      (sel),
        .start    (start),
        .byte_vld (byte_vld),
        .rx_byte  (rx_byte)
    );

    rtcs_xact_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .start     (start),
        .byte_vld  (byte_vld),
        .rx_byte   (rx_byte),
        .ptr       (ptr),
        .wr_stb    (wr_stb),
        .wr_active (wr_active)
    );

    rtcs_regbank #(
        .RAM_BASE  (RAM_BASE),
        .RAM_DEPTH (RAM_DEPTH)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .xact_start (start),
        .wr_stb     (wr_stb),
        .wr_active  (wr_active),
        .wr_addr    (ptr),
        .wr_data    (rx_byte),
        .tick       (tick),
        .rd_addr    (ptr),
        .rd_data    (tx_byte)
    );
endmodule

// File: tb/tb_rtc_spi_regfile.sv
`timescale 1ns/1ps
module tb_rtc_spi_regfile;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sck = 1'b1;
    logic mosi = 1'b0;
    logic tick = 1'b0;
    logic miso;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m [0:127];
    logic [7:0] txd [0:15];
    logic [7:0] rxd [0:15];

    always #4 clk = ~clk;

    rtc_spi_regfile dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck),
        .mosi(mosi), .tick(tick), .miso(miso)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // R1: output quiet while deselected, compared every clock
    always @(negedge clk) begin
        #1;
        if (rst_n && !cs && !done) check("R1 miso idle", {7'b0, miso}, 8'h00);
    end

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int n);
        return 8'((n / 10) * 16 + (n % 10));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m[i] = 8'h00;
        m[3] = 8'h01; m[4] = 8'h01; m[5] = 8'h01; m[15] = 8'h40;
    endtask

    task automatic model_write(input int a, input logic [7:0] d, input bit locked);
        if (a == 15) begin
            if (locked) m[15] = (m[15] & 8'hBF) | (d & 8'h40);
            else        m[15] = d & 8'h47;
        end else if (!locked) begin
            if (a <= 14 || a == 17 || (a >= 32 && a <= 63)) m[a] = d;
        end
    endtask

    task automatic model_tick();
        int s, mi, h, d, mo, y, ml;
        bit pm, carry;
        s = b2i(m[0]);
        if (s < 59) begin m[0] = i2b(s + 1); return; end
        m[0] = 8'h00;
        mi = b2i(m[1]);
        if (mi < 59) begin m[1] = i2b(mi + 1); return; end
        m[1] = 8'h00;
        carry = 1'b0;
        if (m[2][6]) begin
            h = b2i(m[2] & 8'h1F); pm = m[2][5];
            if (h == 11) begin h = 12; carry = pm; pm = !pm; end
            else if (h == 12) h = 1;
            else h = h + 1;
            m[2] = 8'h40 | (pm ? 8'h20 : 8'h00) | i2b(h);
        end else begin
            h = b2i(m[2] & 8'h3F);
            if (h < 23) m[2] = i2b(h + 1);
            else begin m[2] = 8'h00; carry = 1'b1; end
        end
        if (!carry) return;
        m[3] = (m[3] >= 7) ? 8'h01 : m[3] + 8'h01;
        mo = b2i(m[5]); y = b2i(m[6]); d = b2i(m[4]);
        if (mo == 2) ml = (y % 4 == 0) ? 29 : 28;
        else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) ml = 30;
        else ml = 31;
        if (d < ml) begin m[4] = i2b(d + 1); return; end
        m[4] = 8'h01;
        if (mo < 12) begin m[5] = i2b(mo + 1); return; end
        m[5] = 8'h01;
        m[6] = (y == 99) ? 8'h00 : i2b(y + 1);
    endtask

    // mode 3 byte: fall launches, rise samples, MSB first (R1)
    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sck = 1'b0; mosi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic xact(input bit wr, input logic [6:0] a, input int n, input bit tick_mid);
        logic [7:0] r;
        @(negedge clk); cs = 1'b1;
        repeat (3) @(negedge clk);
        spi_byte({wr, a}, r);
        for (int k = 0; k < n; k++) begin
            if (tick_mid && k == 1) begin
                tick = 1'b1; @(negedge clk); tick = 1'b0;
            end
            spi_byte(wr ? txd[k] : 8'h00, r);
            rxd[k] = r;
        end
        repeat (3) @(negedge clk); cs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_bytes(input logic [6:0] a, input int n, input bit tick_mid);
        bit locked;
        locked = m[15][6];
        xact(1'b1, a, n, tick_mid);
        for (int k = 0; k < n; k++) model_write(int'(7'(a + 7'(k))), txd[k], locked);
    endtask

    task automatic rd_chk(input logic [6:0] a, input int n, input string req);
        xact(1'b0, a, n, 1'b0);
        for (int k = 0; k < n; k++)
            check($sformatf("%s addr %h", req, 7'(a + 7'(k))), rxd[k], m[int'(7'(a + 7'(k)))]);
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        model_tick();
        repeat (2) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, dw, d, mo, y);
        txd[0] = s; txd[1] = mi; txd[2] = h; txd[3] = dw;
        txd[4] = d; txd[5] = mo; txd[6] = y;
        wr_bytes(7'h00, 7, 1'b0);
    endtask

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        rd_chk(7'h00, 18, "R5 reset burst R2 R3");
        // locked write ignored
        txd[0] = 8'h33; wr_bytes(7'h00, 1, 1'b0);
        rd_chk(7'h00, 1, "R6 locked seconds");
        // lock cleared mid-burst still honoured for this transaction
        txd[0] = 8'hAA; txd[1] = 8'h00; wr_bytes(7'h0E, 2, 1'b0);
        rd_chk(7'h0E, 2, "R6 R7 same-xact unlock");
        txd[0] = 8'hFF; wr_bytes(7'h0F, 1, 1'b0);
        rd_chk(7'h0F, 1, "R7 ctrl mask");
        txd[0] = 8'h00; wr_bytes(7'h0F, 1, 1'b0);
        rd_chk(7'h0F, 1, "R7 locked ctrl low bits");
        txd[0] = 8'h00; wr_bytes(7'h0F, 1, 1'b0);
        rd_chk(7'h0F, 1, "R7 unlocked clear");
        // RAM edge and holes
        txd[0] = 8'h11; txd[1] = 8'h22; txd[2] = 8'h33; txd[3] = 8'h44;
        wr_bytes(7'h3E, 4, 1'b0);
        rd_chk(7'h3D, 6, "R4 ram edge");
        txd[0] = 8'hEE; txd[1] = 8'h5C; txd[2] = 8'h77; wr_bytes(7'h10, 3, 1'b0);
        for (int k = 0; k < 8; k++) txd[k] = 8'h10 + 8'(k * 3);
        wr_bytes(7'h07, 8, 1'b0);
        rd_chk(7'h07, 12, "R4 alarms charge holes");
        // address wrap
        txd[0] = 8'h99; txd[1] = 8'h12; wr_bytes(7'h7F, 2, 1'b0);
        rd_chk(7'h7E, 3, "R3 wrap");
        // calendar
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
        rd_chk(7'h00, 7, "R2 time burst");
        do_tick(); rd_chk(7'h00, 7, "R8 seconds");
        do_tick(); rd_chk(7'h00, 7, "R10 feb non-leap");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        do_tick(); rd_chk(7'h00, 7, "R10 leap 29");
        do_tick(); rd_chk(7'h00, 3, "R8 after leap");
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
        do_tick(); rd_chk(7'h00, 7, "R10 leap end");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24);
        do_tick(); rd_chk(7'h00, 7, "R10 thirty");
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick(); rd_chk(7'h00, 7, "R11 year wrap");
        set_time(8'h59, 8'h59, 8'h71, 8'h02, 8'h15, 8'h06, 8'h24);
        do_tick(); rd_chk(7'h00, 7, "R9 11PM to 12AM");
        txd[0] = 8'h59; txd[1] = 8'h59; txd[2] = 8'h51; wr_bytes(7'h00, 3, 1'b0);
        do_tick(); rd_chk(7'h00, 7, "R9 11AM to 12PM");
        txd[0] = 8'h59; txd[1] = 8'h59; txd[2] = 8'h52; wr_bytes(7'h00, 3, 1'b0);
        do_tick(); rd_chk(7'h00, 7, "R9 12AM to 1AM");
        txd[0] = 8'h59; txd[1] = 8'h09; txd[2] = 8'h09; wr_bytes(7'h00, 3, 1'b0);
        do_tick(); rd_chk(7'h00, 3, "R8 minute carry");
        // tick during write is dropped
        txd[0] = 8'h01; txd[1] = 8'h02; txd[2] = 8'h03; wr_bytes(7'h20, 3, 1'b1);
        rd_chk(7'h00, 3, "R12 tick dropped");
        rd_chk(7'h20, 3, "R12 write intact");
        // relock
        txd[0] = 8'h40; wr_bytes(7'h0F, 1, 1'b0);
        txd[0] = 8'h99; wr_bytes(7'h20, 1, 1'b0);
        rd_chk(7'h20, 1, "R6 ram locked");
        do_tick(); rd_chk(7'h00, 3, "R8 tick while locked");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule